// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block joins a fast 12-bit port (A) to a slower 24-bit port built from two 12-bit halves (1B and 2B), all on one clock. Going from A to B, two narrow words that arrive on consecutive cycles are gathered so that they leave together as one wide word. The earlier word comes out on 1B and the later word on 2B. The 1B path has two register stages. The 2B path has one.

Going from B to A, each half has its own capture register. A select input picks which captured half drives A. Every data register loads on the rising clock edge when its own active-low clock enable is low. The select input and both active-low output enables pass through a register first, so a change of bus direction takes effect on a clock edge.

Tri-state pins are modelled as separate input, output and output-enable signals. A synchronous active-high reset clears all data storage and sets both registered enables to the disabled (high) state. Without that reset, the enable state is unknown until the first clock edge.

Top module: `bus_xchg`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `aOut`, `b1Out` and `b2Out` to 0 and sets `aOeN` and `bOeN` to 1. The select register returns to 0.
- R2: `ldFirstN` low at an edge loads `aIn` into the first 1B stage only. By itself it changes no output port.
- R3: `ldWideN` low at an edge loads `aIn` into the 2B register, which drives `b2Out`.
- R4: A word on `aIn` with `ldFirstN` low, followed on the next cycle by a word with `ldWideN` low, gives `b1Out` = first word and `b2Out` = second word after the second edge. This also holds when both enables are low together.
- R5: While `ldWideN` is high, `b1Out` and `b2Out` keep their values.
- R6: `capB1N` low at an edge captures `b1In`, and `capB2N` low captures `b2In`. A capture register whose enable is high keeps its value.
- R7: `pickB2` is registered. After an edge with `pickB2` = 0, `aOut` shows the 1B capture register. After an edge with `pickB2` = 1, it shows the 2B capture register. A change between edges leaves `aOut` unchanged.
- R8: After each edge out of reset, `aOeN` equals the value `oeAN` had at that edge, and `bOeN` equals the value `oeBN` had at that edge. A change between edges has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 12 | Narrow port input data |
| aOut | output | 12 | Narrow port output data (selected captured half) |
| aOeN | output | 1 | Registered narrow-port drive enable, active low |
| b1In | input | 12 | Wide port low-half input data |
| b1Out | output | 12 | Wide port low-half output (earlier word) |
| b2In | input | 12 | Wide port high-half input data |
| b2Out | output | 12 | Wide port high-half output (later word) |
| bOeN | output | 1 | Registered wide-port drive enable, active low |
| ldFirstN | input | 1 | Enable for first 1B pipeline stage, active low |
| ldWideN | input | 1 | Enable for second 1B stage and 2B register, active low |
| capB1N | input | 1 | Enable for 1B-to-A capture register, active low |
| capB2N | input | 1 | Enable for 2B-to-A capture register, active low |
| pickB2 | input | 1 | Source select for `aOut`: 0 = 1B capture, 1 = 2B capture |
| oeAN | input | 1 | Narrow-port output enable request, active low |
| oeBN | input | 1 | Wide-port output enable request, active low |

## Verification
The hardest case to reach is the one where both A-side enables are low in the same cycle. The first 1B stage then takes a new word while the second stage moves the old one forward. Only a value loaded two edges earlier shows whether the stages are ordered correctly.

The stimulus reaches this case with a loaded first stage followed by a cycle with both enables low. It then checks that 1B shows the older word and 2B the newer one. A further cycle then checks that the newer word moves up correctly.

For the registered select and enables, the bench changes them between edges. It samples the outputs before the next edge to show they did not move, then samples again after the edge.

// File: rtl/bus_xchg_pkg.sv
package bus_xchg_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic loadFirst;  // first 1B pipeline stage
    logic loadWide;   // later 1B stages and 2B register
    logic capLow;     // 1B-to-A capture
    logic capHigh;    // 2B-to-A capture
    logic pickHigh;   // registered A source select
  } xchg_strobe_t;
endpackage

// File: rtl/bus_xchg_ctrl.sv
module bus_xchg_ctrl
  import bus_xchg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ldFirstN,
  input  logic         ldWideN,
  input  logic         capB1N,
  input  logic         capB2N,
  input  logic         pickB2,
  input  logic         oeAN,
  input  logic         oeBN,
  output xchg_strobe_t strb,
  output logic         aOeN,
  output logic         bOeN
);
  logic pickQ;
  logic oeAQ;
  logic oeBQ;

  // Direction-related controls pass through a register.
  always_ff @(posedge clk) begin
    if (rst) begin
      pickQ <= 1'b0;
      oeAQ  <= 1'b1;
      oeBQ  <= 1'b1;
    end else begin
      pickQ <= pickB2;
      oeAQ  <= oeAN;
      oeBQ  <= oeBN;
    end
  end

  always_comb begin
    strb.loadFirst = ~ldFirstN;
    strb.loadWide  = ~ldWideN;
    strb.capLow    = ~capB1N;
    strb.capHigh   = ~capB2N;
    strb.pickHigh  = pickQ;
  end

  assign aOeN = oeAQ;
  assign bOeN = oeBQ;
endmodule

// File: rtl/bus_xchg_datapath.sv
module bus_xchg_datapath
  import bus_xchg_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  xchg_strobe_t strb,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b1In,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] aOut,
  output logic [W-1:0] b1Out,
  output logic [W-1:0] b2Out
);
  localparam int LAST = DEPTH - 1;

  logic [W-1:0] lowPipe [DEPTH];
  logic [W-1:0] highReg;
  logic [W-1:0] capLowQ;
  logic [W-1:0] capHighQ;

  // Low-half pipeline: stage 0 takes the narrow word, later stages advance with the wide load.
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)                 lowPipe[g] <= '0;
        else if (strb.loadFirst) lowPipe[g] <= aIn;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)                lowPipe[g] <= '0;
        else if (strb.loadWide) lowPipe[g] <= lowPipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      highReg  <= '0;
      capLowQ  <= '0;
      capHighQ <= '0;
    end else begin
      if (strb.loadWide) highReg  <= aIn;
      if (strb.capLow)   capLowQ  <= b1In;
      if (strb.capHigh)  capHighQ <= b2In;
    end
  end

  assign b1Out = lowPipe[LAST];
  assign b2Out = highReg;
  assign aOut  = strb.pickHigh ? capHighQ : capLowQ;
endmodule

// File: rtl/bus_xchg.sv
module bus_xchg
  import bus_xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic         aOeN,
  input  logic [W-1:0] b1In,
  output logic [W-1:0] b1Out,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] b2Out,
  output logic         bOeN,
  input  logic         ldFirstN,
  input  logic         ldWideN,
  input  logic         capB1N,
  input  logic         capB2N,
  input  logic         pickB2,
  input  logic         oeAN,
  input  logic         oeBN
);
  xchg_strobe_t strb;

  bus_xchg_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ldFirstN(ldFirstN), .ldWideN(ldWideN),
    .capB1N(capB1N), .capB2N(capB2N),
    .pickB2(pickB2), .oeAN(oeAN), .oeBN(oeBN),
    .strb(strb), .aOeN(aOeN), .bOeN(bOeN)
  );

  bus_xchg_datapath #(.W(W), .DEPTH(2)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .aOut(aOut), .b1Out(b1Out), .b2Out(b2Out)
  );
endmodule

// File: rtl/bus_xchg_chk.sv
module bus_xchg_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] aIn,
  input logic [W-1:0] aOut,
  input logic         aOeN,
  input logic [W-1:0] b1In,
  input logic [W-1:0] b1Out,
  input logic [W-1:0] b2In,
  input logic [W-1:0] b2Out,
  input logic         bOeN,
  input logic         ldFirstN,
  input logic         ldWideN,
  input logic         capB1N,
  input logic         capB2N,
  input logic         pickB2,
  input logic         oeAN,
  input logic         oeBN
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (aOeN && bOeN && aOut == '0 && b1Out == '0 && b2Out == '0));

  p_wide_load_r3: assert property (@(posedge clk) disable iff (rst)
    !ldWideN |=> b2Out == $past(aIn));

  p_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (!ldFirstN ##1 !ldWideN) |=> b1Out == $past(aIn, 2));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ldWideN |=> ($stable(b1Out) && $stable(b2Out)));

  p_pick_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!capB1N && !pickB2) |=> aOut == $past(b1In));

  p_pick_high_r7: assert property (@(posedge clk) disable iff (rst)
    (!capB2N && pickB2) |=> aOut == $past(b2In));

  p_oe_lag_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (aOeN == $past(oeAN) && bOeN == $past(oeBN)));
endmodule

bind bus_xchg bus_xchg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .aIn(aIn), .aOut(aOut), .aOeN(aOeN),
  .b1In(b1In), .b1Out(b1Out), .b2In(b2In), .b2Out(b2Out), .bOeN(bOeN),
  .ldFirstN(ldFirstN), .ldWideN(ldWideN), .capB1N(capB1N), .capB2N(capB2N),
  .pickB2(pickB2), .oeAN(oeAN), .oeBN(oeBN)
);

// File: tb/bus_xchg_test.sv
`timescale 1ns/1ps
module bus_xchg_test;
  localparam int W = 12;

  typedef struct packed {
    logic rst, a1, a2, c1, c2, sel, oeA, oeB;
    logic [W-1:0] aIn, b1In, b2In;
    logic [W-1:0] eA, eB1, eB2;
    logic eAOe, eBOe;
  } vec_t;

  // fields: rst ldFirstN ldWideN capB1N capB2N pickB2 oeAN oeBN aIn b1In b2In | aOut b1Out b2Out aOeN bOeN
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1,1,1,1,1,0,1,1, 12'h000,12'h000,12'h000, 12'h000,12'h000,12'h000, 1,1}, // R1
    '{0,0,1,1,1,0,0,0, 12'h111,12'h000,12'h000, 12'h000,12'h000,12'h000, 0,0}, // R2 no port effect
    '{0,1,0,1,1,0,1,0, 12'h222,12'h000,12'h000, 12'h000,12'h111,12'h222, 1,0}, // R4 pair
    '{0,0,1,1,1,0,1,0, 12'h333,12'h000,12'h000, 12'h000,12'h111,12'h222, 1,0}, // R5 hold
    '{0,1,0,1,1,0,1,0, 12'h444,12'h000,12'h000, 12'h000,12'h333,12'h444, 1,0}, // R4
    '{0,0,0,1,1,0,1,0, 12'h555,12'h000,12'h000, 12'h000,12'h333,12'h555, 1,0}, // both low
    '{0,1,0,1,1,0,1,0, 12'h666,12'h000,12'h000, 12'h000,12'h555,12'h666, 1,0}, // R3
    '{0,1,1,1,1,0,1,0, 12'h777,12'h000,12'h000, 12'h000,12'h555,12'h666, 1,0}, // R5
    '{0,1,1,0,1,0,0,1, 12'h000,12'hABC,12'hDEF, 12'hABC,12'h555,12'h666, 0,1}, // R6 low
    '{0,1,1,1,0,1,0,1, 12'h000,12'h123,12'hDEF, 12'hDEF,12'h555,12'h666, 0,1}, // R6 high, R7
    '{0,1,1,0,1,1,0,1, 12'h000,12'h456,12'hAAA, 12'hDEF,12'h555,12'h666, 0,1}, // R7 shows high
    '{0,1,1,1,1,0,0,1, 12'h000,12'hFFF,12'hAAA, 12'h456,12'h555,12'h666, 0,1}, // R7 low, R6 hold
    '{0,1,1,1,0,0,0,1, 12'h000,12'hFFF,12'h789, 12'h456,12'h555,12'h666, 0,1}, // R6
    '{0,1,1,1,1,1,0,1, 12'h000,12'hFFF,12'h000, 12'h789,12'h555,12'h666, 0,1}, // R7
    '{1,0,0,0,0,1,0,0, 12'hAAA,12'hBBB,12'hCCC, 12'h000,12'h000,12'h000, 1,1}  // R1 mid-run
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, b1In = '0, b2In = '0;
  logic ldFirstN = 1'b1, ldWideN = 1'b1, capB1N = 1'b1, capB2N = 1'b1;
  logic pickB2 = 1'b0, oeAN = 1'b1, oeBN = 1'b1;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic aOeN, bOeN;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  bus_xchg #(.W(W)) uut (
    .clk(clk), .rst(rst), .aIn(aIn), .aOut(aOut), .aOeN(aOeN),
    .b1In(b1In), .b1Out(b1Out), .b2In(b2In), .b2Out(b2Out), .bOeN(bOeN),
    .ldFirstN(ldFirstN), .ldWideN(ldWideN), .capB1N(capB1N), .capB2N(capB2N),
    .pickB2(pickB2), .oeAN(oeAN), .oeBN(oeBN)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ldFirstN = 1'b1; ldWideN = 1'b1; capB1N = 1'b1; capB2N = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      rst = VEC[i].rst; ldFirstN = VEC[i].a1; ldWideN = VEC[i].a2;
      capB1N = VEC[i].c1; capB2N = VEC[i].c2; pickB2 = VEC[i].sel;
      oeAN = VEC[i].oeA; oeBN = VEC[i].oeB;
      aIn = VEC[i].aIn; b1In = VEC[i].b1In; b2In = VEC[i].b2In;
      @(negedge clk);
      check(VEC[i].rst ? "R1 aOut" : "R6 R7 aOut", aOut, VEC[i].eA);
      check(VEC[i].rst ? "R1 b1Out" : "R2 R4 R5 b1Out", b1Out, VEC[i].eB1);
      check(VEC[i].rst ? "R1 b2Out" : "R3 R5 b2Out", b2Out, VEC[i].eB2);
      check(VEC[i].rst ? "R1 aOeN" : "R8 aOeN", {{(W-1){1'b0}}, aOeN}, {{(W-1){1'b0}}, VEC[i].eAOe});
      check(VEC[i].rst ? "R1 bOeN" : "R8 bOeN", {{(W-1){1'b0}}, bOeN}, {{(W-1){1'b0}}, VEC[i].eBOe});
    end

    // R7: select change between edges leaves aOut alone until the next edge
    rst = 1'b0; idle(); pickB2 = 1'b0; oeAN = 1'b1; oeBN = 1'b1;
    capB1N = 1'b0; capB2N = 1'b0; b1In = 12'h0AA; b2In = 12'h0BB;
    @(negedge clk);
    check("R7 low after capture", aOut, 12'h0AA);
    idle(); pickB2 = 1'b1;
    #5;
    check("R7 no change before edge", aOut, 12'h0AA);
    @(negedge clk);
    check("R7 high after edge", aOut, 12'h0BB);

    // R8: enable request between edges has no effect until the edge
    oeAN = 1'b0; oeBN = 1'b0;
    #5;
    check("R8 aOeN before edge", {{(W-1){1'b0}}, aOeN}, {{(W-1){1'b0}}, 1'b1});
    check("R8 bOeN before edge", {{(W-1){1'b0}}, bOeN}, {{(W-1){1'b0}}, 1'b1});
    @(negedge clk);
    check("R8 aOeN after edge", {{(W-1){1'b0}}, aOeN}, '0);
    check("R8 bOeN after edge", {{(W-1){1'b0}}, bOeN}, '0);

    // R4: all-ones then all-zeros pair
    ldFirstN = 1'b0; aIn = 12'hFFF;
    @(negedge clk);
    ldFirstN = 1'b1; ldWideN = 1'b0; aIn = 12'h000;
    @(negedge clk);
    check("R4 b1Out ones", b1Out, 12'hFFF);
    check("R4 b2Out zeros", b2Out, 12'h000);
    // R2: first stage load alone leaves both wide halves unchanged
    ldWideN = 1'b1; ldFirstN = 1'b0; aIn = 12'h5A5;
    @(negedge clk);
    idle();
    check("R2 b1Out unchanged", b1Out, 12'hFFF);
    check("R2 b2Out unchanged", b2Out, 12'h000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule